// File: doc/BRIEF.md
# Eight-Bit Arithmetic-Logic Unit with Extended Status Flags

This block is a purely combinational arithmetic-logic unit for two 8-bit operands. A 4-bit opcode selects one of sixteen functions. These are bitwise logic, signed and unsigned addition, addition with an incoming carry, unsigned subtraction, signed and unsigned multiplication, single-position rotates and shifts, and conversion of a four-digit packed decimal number to binary. The low result byte leaves on one port and the high byte on another. The high byte carries data only for the multiplies and the decimal conversion.

Beside the result, the unit reports a zero flag, a carry/borrow flag, a signed overflow flag, a negative flag and a combined flag that is the OR of zero, carry and overflow. It also reports two properties of the low result byte: whether its bit pattern is mirror-symmetric, and whether its unsigned value is a prime number. The unit has no clock and no state. Every output settles from the current inputs alone.

Top module: `alu8_status`

## Requirements
- R1: Opcodes 0 (AND), 1 (OR), 2 (XOR) and 3 (XNOR) drive the bitwise function of opA and opB onto resLo; carryOut and ovfFlag are 0.
- R2: Opcode 4 gives {carryOut,resLo} = opA + opB; opcode 6 gives {carryOut,resLo} = opA + opB + carryIn.
- R3: Opcode 5 gives resLo = (opA + opB) mod 256 with carryOut = 0. ovfFlag is 1 exactly when opA[7] equals opB[7] and resLo[7] differs from them.
- R4: Opcode 7 (signed) and opcode 8 (unsigned) give {resHi,resLo} = the 16-bit product. For opcode 7, ovfFlag is 1 when the product lies outside -128..127. For opcode 8, ovfFlag is 0.
- R5: Opcode 9 gives resLo = (opA - opB) mod 256, with carryOut = 1 exactly when opA < opB.
- R6: Opcode 10 rotates opA left by one: resLo = {opA[6:0],opA[7]}. Opcode 11 rotates the 9-bit value {carryIn,opA} left by one: resLo = {opA[6:0],carryIn}. On both, carryOut = opA[7].
- R7: Opcode 12 gives resLo = {0,opA[7:1]}, opcode 13 gives resLo = {opA[7],opA[7:1]}, and on both carryOut = opA[0]. Opcode 14 gives resLo = {opA[6:0],0} with carryOut = opA[7].
- R8: Opcode 15 reads {opB,opA} as four decimal digits, most significant in opB[7:4], and puts the 16-bit binary value on {resHi,resLo}. Only digits 0..9 are defined.
- R9: resHi is 0 on every opcode other than 7, 8 and 15. carryOut is 0 on opcodes 0-3, 7, 8 and 15. ovfFlag is 0 on every opcode other than 5 and 7.
- R10: zeroFlag is 1 exactly when all 16 bits of {resHi,resLo} are 0.
- R11: negFlag equals resLo[7], and anyFlag equals zeroFlag | carryOut | ovfFlag.
- R12: palFlag is 1 exactly when resLo[i] equals resLo[7-i] for every i.
- R13: primeFlag is 1 exactly when resLo, read as unsigned, is prime. 0 and 1 are not prime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand, low decimal digits for opcode 15 |
| opB | input | 8 | Second operand, high decimal digits for opcode 15 |
| carryIn | input | 1 | Incoming carry for opcodes 6 and 11 |
| opcode | input | 4 | Function select |
| resLo | output | 8 | Result, or low byte of a 16-bit result |
| resHi | output | 8 | High byte of a 16-bit result, otherwise zero |
| zeroFlag | output | 1 | Whole result is zero |
| carryOut | output | 1 | Carry, borrow or bit moved out |
| ovfFlag | output | 1 | Signed overflow |
| anyFlag | output | 1 | OR of zero, carry and overflow |
| palFlag | output | 1 | resLo is bit-mirror symmetric |
| primeFlag | output | 1 | resLo is a prime number |
| negFlag | output | 1 | resLo is negative as a signed byte |

## Verification
No register lies between any input and any output, so each result and each flag is due in the same cycle that a new operand or opcode is applied. The bench changes inputs only on the falling clock edge. It reads every output a fixed 2 ns later, well before the next rising edge, and compares the full output vector against a model written from the requirements. The primality and mirror-symmetry flags get an extra pass over all 256 values of the low result byte.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_XNOR  = 4'd3,
    OP_ADDU  = 4'd4,
    OP_ADDS  = 4'd5,
    OP_ADDC  = 4'd6,
    OP_MULS  = 4'd7,
    OP_MULU  = 4'd8,
    OP_SUBU  = 4'd9,
    OP_ROL   = 4'd10,
    OP_RCL   = 4'd11,
    OP_LSR   = 4'd12,
    OP_ASR   = 4'd13,
    OP_LSL   = 4'd14,
    OP_BCD   = 4'd15
  } aluOpE;

  typedef enum logic [2:0] {
    RES_LOGIC = 3'd0,
    RES_ADD   = 3'd1,
    RES_MUL   = 3'd2,
    RES_SHIFT = 3'd3,
    RES_BCD   = 3'd4
  } resSelE;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_XNOR = 2'd3
  } logicFnE;

  typedef enum logic [2:0] {
    SH_ROL = 3'd0,
    SH_RCL = 3'd1,
    SH_LSR = 3'd2,
    SH_ASR = 3'd3,
    SH_LSL = 3'd4
  } shKindE;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSelE  resSel;
    logicFnE logicFn;
    logic    addCin;     // add the incoming carry
    logic    addSub;     // subtract instead of add
    logic    addSigned;  // signed add: no carry, overflow tracked
    logic    mulSigned;
    shKindE  shKind;
    logic    wide;       // result occupies both bytes
  } aluCtrlT;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opcode,
  output aluCtrlT    ctrl
);

  aluOpE op;
  assign op = aluOpE'(opcode);

  always_comb begin
    ctrl.resSel    = RES_LOGIC;
    ctrl.logicFn   = LG_AND;
    ctrl.addCin    = 1'b0;
    ctrl.addSub    = 1'b0;
    ctrl.addSigned = 1'b0;
    ctrl.mulSigned = 1'b0;
    ctrl.shKind    = SH_ROL;
    ctrl.wide      = 1'b0;
    unique case (op)
      OP_AND:  ctrl.logicFn = LG_AND;
      OP_OR:   ctrl.logicFn = LG_OR;
      OP_XOR:  ctrl.logicFn = LG_XOR;
      OP_XNOR: ctrl.logicFn = LG_XNOR;
      OP_ADDU: ctrl.resSel  = RES_ADD;
      OP_ADDS: begin
        ctrl.resSel    = RES_ADD;
        ctrl.addSigned = 1'b1;
      end
      OP_ADDC: begin
        ctrl.resSel = RES_ADD;
        ctrl.addCin = 1'b1;
      end
      OP_MULS: begin
        ctrl.resSel    = RES_MUL;
        ctrl.mulSigned = 1'b1;
        ctrl.wide      = 1'b1;
      end
      OP_MULU: begin
        ctrl.resSel = RES_MUL;
        ctrl.wide   = 1'b1;
      end
      OP_SUBU: begin
        ctrl.resSel = RES_ADD;
        ctrl.addSub = 1'b1;
      end
      OP_ROL: begin
        ctrl.resSel = RES_SHIFT;
        ctrl.shKind = SH_ROL;
      end
      OP_RCL: begin
        ctrl.resSel = RES_SHIFT;
        ctrl.shKind = SH_RCL;
      end
      OP_LSR: begin
        ctrl.resSel = RES_SHIFT;
        ctrl.shKind = SH_LSR;
      end
      OP_ASR: begin
        ctrl.resSel = RES_SHIFT;
        ctrl.shKind = SH_ASR;
      end
      OP_LSL: begin
        ctrl.resSel = RES_SHIFT;
        ctrl.shKind = SH_LSL;
      end
      OP_BCD: begin
        ctrl.resSel = RES_BCD;
        ctrl.wide   = 1'b1;
      end
      default: ctrl.resSel = RES_LOGIC;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  aluCtrlT      ctrl,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         carry,
  output logic         ovf
);

  localparam int W2     = 2 * W;
  localparam int DIGITS = W2 / 4;
  localparam logic [W2-1:0] TEN = W2'(10);

  // ---------------- logic unit ----------------
  logic [W-1:0] logicRes;
  always_comb begin
    unique case (ctrl.logicFn)
      LG_AND:  logicRes = a & b;
      LG_OR:   logicRes = a | b;
      LG_XOR:  logicRes = a ^ b;
      default: logicRes = ~(a ^ b);
    endcase
  end

  // ---------------- shared adder / subtractor ----------------
  logic [W-1:0] addB;
  logic         addC0;
  logic [W:0]   sum;
  logic         addCarry, addOvf;

  assign addB  = ctrl.addSub ? ~b : b;
  assign addC0 = ctrl.addSub | (ctrl.addCin & cin);
  assign sum   = {1'b0, a} + {1'b0, addB} + {{W{1'b0}}, addC0};

  always_comb begin
    if (ctrl.addSub)         addCarry = ~sum[W];  // borrow
    else if (ctrl.addSigned) addCarry = 1'b0;
    else                     addCarry = sum[W];
  end
  assign addOvf = ctrl.addSigned & (a[W-1] == b[W-1]) & (sum[W-1] != a[W-1]);

  // ---------------- multiplier ----------------
  logic [W2-1:0] aExt, bExt, prod;
  logic          mulOvf;
  assign aExt = ctrl.mulSigned ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
  assign bExt = ctrl.mulSigned ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
  assign prod = aExt * bExt;
  assign mulOvf = ctrl.mulSigned &
                  ~((&prod[W2-1:W-1]) | ~(|prod[W2-1:W-1]));

  // ---------------- single-position shifter ----------------
  logic [W-1:0] shRes;
  logic         shOut;
  always_comb begin
    unique case (ctrl.shKind)
      SH_RCL: begin shRes = {a[W-2:0], cin};     shOut = a[W-1]; end
      SH_LSR: begin shRes = {1'b0, a[W-1:1]};    shOut = a[0];   end
      SH_ASR: begin shRes = {a[W-1], a[W-1:1]};  shOut = a[0];   end
      SH_LSL: begin shRes = {a[W-2:0], 1'b0};    shOut = a[W-1]; end
      default: begin shRes = {a[W-2:0], a[W-1]}; shOut = a[W-1]; end
    endcase
  end

  // ---------------- packed decimal to binary (Horner form) ----------------
  logic [W2-1:0] bcdIn, bcdVal;
  assign bcdIn = {b, a};
  always_comb begin
    bcdVal = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      bcdVal = bcdVal * TEN + {{(W2-4){1'b0}}, bcdIn[4*i +: 4]};
    end
  end

  // ---------------- result and flag steering ----------------
  always_comb begin
    xOut  = logicRes;
    yOut  = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    unique case (ctrl.resSel)
      RES_ADD: begin
        xOut  = sum[W-1:0];
        carry = addCarry;
        ovf   = addOvf;
      end
      RES_MUL: begin
        {yOut, xOut} = prod;
        ovf          = mulOvf;
      end
      RES_SHIFT: begin
        xOut  = shRes;
        carry = shOut;
      end
      RES_BCD: {yOut, xOut} = bcdVal;
      default: xOut = logicRes;
    endcase
  end

  // ---------------- checks against the decoder ----------------
  always_comb begin
    // R9
    wide_y_zero_chk: assert (ctrl.wide || yOut == '0)
      else $error("high byte non-zero on a single-byte opcode");
    // R9
    carry_quiet_chk: assert (!(ctrl.resSel inside {RES_LOGIC, RES_MUL, RES_BCD}) || !carry)
      else $error("carry set on an opcode that produces none");
    // R5
    sub_borrow_chk: assert (!(ctrl.resSel == RES_ADD && ctrl.addSub) || (carry == (xOut > a)))
      else $error("borrow does not match wrapped difference");
    // R2
    add_wrap_chk: assert (!(ctrl.resSel == RES_ADD && !ctrl.addSub && !ctrl.addSigned && !carry)
                          || (xOut >= a))
      else $error("unsigned sum wrapped without carry");
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] xVal,
  input  logic [W-1:0] yVal,
  input  logic         carry,
  input  logic         ovf,
  output logic         zero,
  output logic         anyFlag,
  output logic         neg,
  output logic         pal,
  output logic         prime
);

  // trial divisors cover every factor up to the square root of 2**W - 1
  localparam int ROOT = 1 << ((W + 1) / 2);

  assign zero    = ~|{yVal, xVal};
  assign anyFlag = zero | carry | ovf;
  assign neg     = xVal[W-1];

  // mirror symmetry: one comparator per bit pair
  logic [W/2-1:0] pairEq;
  for (genvar i = 0; i < W / 2; i++) begin : g_mirror
    assign pairEq[i] = (xVal[i] == xVal[W-1-i]);
  end
  assign pal = &pairEq;

  // primality: a proper divisor below ROOT marks the value composite
  logic [ROOT-1:2] hasDiv;
  for (genvar d = 2; d < ROOT; d++) begin : g_divisor
    assign hasDiv[d] = (xVal > W'(d)) && ((xVal % W'(d)) == '0);
  end
  assign prime = (xVal > W'(1)) && !(|hasDiv);

  always_comb begin
    // R13
    prime_odd_chk: assert (!prime || xVal[0] || xVal == W'(2))
      else $error("even value other than two flagged prime");
    // R12
    pal_ends_chk: assert (!pal || (xVal[0] == xVal[W-1]))
      else $error("symmetric flag with unequal end bits");
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic [3:0]   opcode,
  output logic [W-1:0] resLo,
  output logic [W-1:0] resHi,
  output logic         zeroFlag,
  output logic         carryOut,
  output logic         ovfFlag,
  output logic         anyFlag,
  output logic         palFlag,
  output logic         primeFlag,
  output logic         negFlag
);

  aluCtrlT ctrl;

  alu_ctrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.W(W)) u_dp (
    .a     (opA),
    .b     (opB),
    .cin   (carryIn),
    .ctrl  (ctrl),
    .xOut  (resLo),
    .yOut  (resHi),
    .carry (carryOut),
    .ovf   (ovfFlag)
  );

  alu_flags #(.W(W)) u_flags (
    .xVal    (resLo),
    .yVal    (resHi),
    .carry   (carryOut),
    .ovf     (ovfFlag),
    .zero    (zeroFlag),
    .anyFlag (anyFlag),
    .neg     (negFlag),
    .pal     (palFlag),
    .prime   (primeFlag)
  );

  always_comb begin
    // R3
    signed_ovf_chk: assert (!(opcode == 4'd5 && ovfFlag) ||
                            (opA[W-1] == opB[W-1] && resLo[W-1] != opA[W-1]))
      else $error("signed overflow without a sign conflict");
  end

endmodule

// File: tb/tb_alu8_status.sv
module tb_alu8_status;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA, opB;
  logic       carryIn;
  logic [3:0] opcode;
  logic [7:0] resLo, resHi;
  logic       zeroFlag, carryOut, ovfFlag, anyFlag, palFlag, primeFlag, negFlag;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  alu8_status dut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opcode(opcode),
    .resLo(resLo), .resHi(resHi), .zeroFlag(zeroFlag), .carryOut(carryOut),
    .ovfFlag(ovfFlag), .anyFlag(anyFlag), .palFlag(palFlag),
    .primeFlag(primeFlag), .negFlag(negFlag)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [3:0] op;
  } vecT;

  localparam int NVEC = 26;
  localparam vecT VEC [NVEC] = '{
    '{8'hF0, 8'h3C, 1'b0, 4'd0}, '{8'hA5, 8'h5A, 1'b0, 4'd1},
    '{8'hFF, 8'h0F, 1'b1, 4'd2}, '{8'h33, 8'h33, 1'b0, 4'd3},
    '{8'hC8, 8'h64, 1'b0, 4'd4}, '{8'h12, 8'h34, 1'b1, 4'd4},
    '{8'h70, 8'h20, 1'b0, 4'd5}, '{8'h80, 8'hFF, 1'b0, 4'd5},
    '{8'hFF, 8'h00, 1'b1, 4'd6}, '{8'h7F, 8'h80, 1'b1, 4'd6},
    '{8'h0C, 8'hF6, 1'b0, 4'd7}, '{8'h80, 8'h80, 1'b0, 4'd7},
    '{8'hFF, 8'hFF, 1'b0, 4'd8}, '{8'h10, 8'h0B, 1'b0, 4'd8},
    '{8'h05, 8'h09, 1'b0, 4'd9}, '{8'h40, 8'h11, 1'b0, 4'd9},
    '{8'h81, 8'h00, 1'b0, 4'd10}, '{8'h81, 8'h00, 1'b0, 4'd11},
    '{8'h40, 8'h00, 1'b1, 4'd11}, '{8'h03, 8'h00, 1'b0, 4'd12},
    '{8'h81, 8'h00, 1'b0, 4'd13}, '{8'h42, 8'h00, 1'b0, 4'd13},
    '{8'hC1, 8'h00, 1'b0, 4'd14}, '{8'h34, 8'h12, 1'b0, 4'd15},
    '{8'h99, 8'h99, 1'b0, 4'd15}, '{8'h07, 8'h00, 1'b1, 4'd15}
  };

  function automatic logic isPrime(input logic [7:0] v);
    if (v < 8'd2) return 1'b0;
    for (int d = 2; d < int'(v); d++) if (int'(v) % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic isPal(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i] != v[7-i]) return 1'b0;
    return 1'b1;
  endfunction

  // packed as {resHi,resLo,zero,carry,ovf,any,pal,prime,neg}
  function automatic logic [22:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic cin, input logic [3:0] op);
    logic [7:0] x, y;
    logic c, v, z;
    logic [8:0] s;
    logic signed [7:0] sa, sb;
    logic signed [15:0] sp;
    int bv;
    x = 8'h00; y = 8'h00; c = 1'b0; v = 1'b0;
    sa = a; sb = b;
    case (op)
      4'd0: x = a & b;
      4'd1: x = a | b;
      4'd2: x = a ^ b;
      4'd3: x = ~(a ^ b);
      4'd4: begin s = a + b; {c, x} = s; end
      4'd5: begin
        x = a + b;
        v = (a[7] == b[7]) && (x[7] != a[7]);
      end
      4'd6: begin s = a + b + {7'd0, cin}; {c, x} = s; end
      4'd7: begin
        sp = sa * sb;
        {y, x} = sp;
        v = (sp > 16'sd127) || (sp < -16'sd128);
      end
      4'd8: {y, x} = a * b;
      4'd9: begin x = a - b; c = (a < b); end
      4'd10: begin x = {a[6:0], a[7]}; c = a[7]; end
      4'd11: begin x = {a[6:0], cin};  c = a[7]; end
      4'd12: begin x = a >> 1;          c = a[0]; end
      4'd13: begin x = {a[7], a[7:1]};  c = a[0]; end
      4'd14: begin x = a << 1;          c = a[7]; end
      default: begin
        bv = int'(b[7:4]) * 1000 + int'(b[3:0]) * 100 + int'(a[7:4]) * 10 + int'(a[3:0]);
        {y, x} = bv[15:0];
      end
    endcase
    z = ({y, x} == 16'h0000);
    return {y, x, z, c, v, z | c | v, isPal(x), isPrime(x), x[7]};
  endfunction

  function automatic string reqTag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: return "R1";
      4'd4, 4'd6:             return "R2";
      4'd5:                   return "R3";
      4'd7, 4'd8:             return "R4";
      4'd9:                   return "R5";
      4'd10, 4'd11:           return "R6";
      4'd12, 4'd13, 4'd14:    return "R7";
      default:                return "R8";
    endcase
  endfunction

  // result is combinational: drive on the falling edge, sample 2 ns later
  task automatic apply(input logic [7:0] a, input logic [7:0] b,
                       input logic cin, input logic [3:0] op);
    @(negedge clk);
    opA = a; opB = b; carryIn = cin; opcode = op;
    #2;
  endtask

  task automatic checkVec(input logic [7:0] a, input logic [7:0] b,
                          input logic cin, input logic [3:0] op, input string tag);
    logic [22:0] got, exp;
    apply(a, b, cin, op);
    exp = model(a, b, cin, op);
    got = {resHi, resLo, zeroFlag, carryOut, ovfFlag, anyFlag, palFlag, primeFlag, negFlag};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0b actual=%06h expected=%06h",
               tag, op, a, b, cin, got, exp);
    end
  endtask

  task automatic checkBit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0; opcode = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state: all-zero inputs give an AND of zero
    checkVec(8'h00, 8'h00, 1'b0, 4'd0, "R10 idle");
    checkBit(zeroFlag, 1'b1, "R10 idle zero");
    checkBit(anyFlag, 1'b1, "R11 idle any");
    checkBit(palFlag, 1'b1, "R12 idle symmetric");
    checkBit(primeFlag, 1'b0, "R13 idle prime");

    // table walk
    for (int i = 0; i < NVEC; i++)
      checkVec(VEC[i].a, VEC[i].b, VEC[i].cin, VEC[i].op, reqTag(VEC[i].op));

    // directed corners
    checkVec(8'hFF, 8'h01, 1'b0, 4'd4, "R10 wrap to zero");
    checkBit(zeroFlag & carryOut, 1'b1, "R10 zero with carry");
    checkVec(8'h00, 8'h5A, 1'b0, 4'd8, "R10 zero product");
    checkVec(8'h80, 8'h01, 1'b0, 4'd7, "R4 min signed fits");
    checkBit(ovfFlag, 1'b0, "R4 -128 no overflow");
    checkVec(8'h80, 8'hFF, 1'b0, 4'd7, "R4 +128 overflows");
    checkBit(ovfFlag, 1'b1, "R4 +128 overflow flag");
    checkVec(8'hFF, 8'hFF, 1'b1, 4'd2, "R9 logic quiet");
    checkBit(resHi == 8'h00 && !carryOut && !ovfFlag, 1'b1, "R9 logic quiet flags");
    checkVec(8'hC8, 8'h64, 1'b0, 4'd5, "R9 signed add no carry");
    checkBit(carryOut, 1'b0, "R3 no carry on signed add");
    checkVec(8'h00, 8'h01, 1'b0, 4'd9, "R5 borrow");
    checkBit(resLo == 8'hFF && carryOut, 1'b1, "R5 borrow value");
    checkVec(8'h99, 8'h99, 1'b0, 4'd15, "R8 max");
    checkBit({resHi, resLo} == 16'h270F, 1'b1, "R8 9999");
    checkVec(8'h90, 8'h00, 1'b0, 4'd1, "R11 negative");
    checkBit(negFlag, 1'b1, "R11 neg flag");
    checkVec(8'h02, 8'h00, 1'b0, 4'd14, "R6 R7 shift left");

    // every low-byte value through OR with zero
    for (int v = 0; v < 256; v++)
      checkVec(8'(v), 8'h00, 1'b0, 4'd1, "R12 R13 sweep");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule